// File: doc/BRIEF.md
# Translation Walk Intermediate-Base Cache

This block keeps the table bases that a hardware translation walker has already fetched, so that a later walk can start part-way down the tree instead of at the root. It holds three small fully-associative arrays, one for each non-leaf level of a four-level radix table. The level-1 array maps a top-level virtual prefix to the second-level table base. The level-2 array maps a longer prefix to the third-level base. The level-3 array maps the longest prefix to the last-level table base.

The walker presents a root frame, a 12-bit context tag and the upper virtual address bits (VA[47:21], here called the region index). One cycle later the block answers with the deepest level that hit and the base stored there. The walker writes an entry after each non-leaf fetch through the fill port. Four maintenance actions remove entries:
- an address invalidate;
- a large-page promotion that clears only the level-3 entry for one 2 MB region;
- a context switch that flushes either everything or only one context.

Top module: `walk_base_cache`

## Requirements
- R1: A lookup presented with `lk_valid` high gives `rsp_valid` high on the next clock. When `rsp_valid` is low, `rsp_level` and `rsp_base` are zero. Out of reset, no response is pending.
- R2: The level-1 tag is root, context and region index bits [26:18] (VA[47:39]). The level-2 tag adds bits [17:9] (VA[38:30]). The level-3 tag adds bits [8:0] (VA[29:21]). `rsp_level` reports 1, 2 or 3 for a hit at that level with the stored base, and 0 with base 0 for a miss.
- R3: When arrays at several levels hit, the response reports the deepest hitting level and its base.
- R4: The context tag is part of every tag. Entries that differ only in context coexist, and a lookup with another context misses.
- R5: A fill whose tag already exists in the target array overwrites that entry in place and does not advance the replacement pointer. No array ever holds two valid entries with equal tags.
- R6: A fill with a new tag writes the slot under a per-array round-robin pointer, then advances it with wrap. With ENTRIES slots, the (ENTRIES+1)-th distinct fill after the pointer reaches a slot evicts the entry written there first.
- R7: `inv_valid` removes, in every array, each entry whose stored prefix equals the matching prefix of `inv_va_hi`, for any root or context. Other entries are kept.
- R8: `ctxsw_valid` with `ctxsw_keep` low removes every entry in all arrays.
- R9: `ctxsw_valid` with `ctxsw_keep` high removes only the entries whose context equals `ctxsw_ctx`.
- R10: `promo_valid` removes only level-3 entries whose region index equals `promo_va_hi`. Level-1 and level-2 entries stay.
- R11: Removals take effect at the same clock edge as a fill, and the fill is applied after them, so a fill survives a flush in the same cycle. A lookup in the same cycle as a fill sees the contents from before that fill.
- R12: A fill with `fill_level` 0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_root | input | ROOT_W | Root table frame of the lookup |
| lk_ctx | input | CTX_W | Context tag of the lookup |
| lk_va_hi | input | 27 | VA[47:21] of the lookup |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_level | output | 2 | Deepest hit level, 0 on miss |
| rsp_base | output | BASE_W | Cached next-level table base |
| fill_valid | input | 1 | Fill request |
| fill_level | input | 2 | Target array 1..3 |
| fill_root | input | ROOT_W | Root frame for the new entry |
| fill_ctx | input | CTX_W | Context for the new entry |
| fill_va_hi | input | 27 | VA[47:21] for the new entry |
| fill_base | input | BASE_W | Next-level base to store |
| inv_valid | input | 1 | Address invalidate |
| inv_va_hi | input | 27 | VA[47:21] to invalidate |
| promo_valid | input | 1 | Large-page promotion invalidate |
| promo_va_hi | input | 27 | VA[47:21] of the promoted 2 MB region |
| ctxsw_valid | input | 1 | Context switch |
| ctxsw_keep | input | 1 | 1: flush one context, 0: flush all |
| ctxsw_ctx | input | CTX_W | Context to flush when keeping |

## Verification
A fill can arrive in the same cycle as a flush. The bench drives a level-1 fill together with a full flush and then looks the entry up. The entry must hit, because removal comes before the fill at the same edge. A lookup can also share a cycle with a fill of its own tag. The bench issues both together, and the response to that lookup must be a miss, while a lookup one cycle later must hit. A behavioural model in the bench follows both orderings and is compared against the ports on every clock.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int LVLS     = 3;
  localparam int IDX_BITS = 9;
  localparam int VA_HI_W  = LVLS * IDX_BITS;
  localparam int LVL_W    = 2;

  typedef logic [LVL_W-1:0] hit_lvl_t;

  // prefix width used by array index g (0-based)
  function automatic int pfx_width(input int g);
    return IDX_BITS * (g + 1);
  endfunction
endpackage

// File: rtl/pwc_level.sv
module pwc_level #(
  parameter int ENTRIES = 8,
  parameter int PW      = 9,
  parameter int ROOT_W  = 40,
  parameter int CTX_W   = 12,
  parameter int BASE_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROOT_W-1:0] lk_root,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic [PW-1:0]     lk_pfx,
  output logic              hit,
  output logic [BASE_W-1:0] hit_base,
  input  logic              fill_en,
  input  logic [ROOT_W-1:0] fill_root,
  input  logic [CTX_W-1:0]  fill_ctx,
  input  logic [PW-1:0]     fill_pfx,
  input  logic [BASE_W-1:0] fill_base,
  input  logic              kill_a_en,
  input  logic [PW-1:0]     kill_a_pfx,
  input  logic              kill_b_en,
  input  logic [PW-1:0]     kill_b_pfx,
  input  logic              flush_all,
  input  logic              flush_ctx_en,
  input  logic [CTX_W-1:0]  flush_ctx
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef struct packed {
    logic [ROOT_W-1:0] root;
    logic [CTX_W-1:0]  ctx;
    logic [PW-1:0]     pfx;
  } tag_t;

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [IW-1:0]      ptr_q, ptr_d;
  tag_t               tag_q  [ENTRIES];
  logic [BASE_W-1:0]  base_q [ENTRIES];

  tag_t               lk_tag, fill_tag;
  logic [ENTRIES-1:0] lk_match, fill_match, kill;
  logic               dup;
  logic [IW-1:0]      dup_idx, wr_idx;

  assign lk_tag   = '{root: lk_root,   ctx: lk_ctx,   pfx: lk_pfx};
  assign fill_tag = '{root: fill_root, ctx: fill_ctx, pfx: fill_pfx};

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i]   = vld_q[i] && (tag_q[i] == lk_tag);
      fill_match[i] = vld_q[i] && (tag_q[i] == fill_tag);
      kill[i]       = flush_all
                    | (flush_ctx_en && (tag_q[i].ctx == flush_ctx))
                    | (kill_a_en    && (tag_q[i].pfx == kill_a_pfx))
                    | (kill_b_en    && (tag_q[i].pfx == kill_b_pfx));
    end
  end

  always_comb begin
    hit_base = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) hit_base = hit_base | base_q[i];
    end
  end
  assign hit = |lk_match;

  always_comb begin
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_match[i]) dup_idx = IW'(i);
    end
  end
  assign dup    = |fill_match;
  assign wr_idx = dup ? dup_idx : ptr_q;

  always_comb begin
    vld_d = vld_q & ~kill;
    ptr_d = ptr_q;
    if (fill_en) begin
      vld_d[wr_idx] = 1'b1;
      if (!dup) begin
        ptr_d = (ptr_q == IW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic wr_en;
    assign wr_en = fill_en && (wr_idx == IW'(e));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q[e]  <= fill_tag;
        base_q[e] <= fill_base;
      end
    end
  end
endmodule

// File: rtl/pwc_pick.sv
module pwc_pick
  import pwc_pkg::*;
#(
  parameter int BASE_W = 40
) (
  input  logic [LVLS-1:0]        hit,
  input  logic [LVLS*BASE_W-1:0] base_flat,
  output hit_lvl_t               level,
  output logic [BASE_W-1:0]      base
);
  // later (deeper) levels override shallower ones
  always_comb begin
    level = '0;
    base  = '0;
    for (int l = 0; l < LVLS; l++) begin
      if (hit[l]) begin
        level = hit_lvl_t'(l + 1);
        base  = base_flat[l*BASE_W +: BASE_W];
      end
    end
  end
endmodule

// File: rtl/walk_base_cache.sv
module walk_base_cache
  import pwc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ROOT_W  = 40,
  parameter int CTX_W   = 12,
  parameter int BASE_W  = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [ROOT_W-1:0]  lk_root,
  input  logic [CTX_W-1:0]   lk_ctx,
  input  logic [VA_HI_W-1:0] lk_va_hi,
  output logic               rsp_valid,
  output logic [LVL_W-1:0]   rsp_level,
  output logic [BASE_W-1:0]  rsp_base,
  input  logic               fill_valid,
  input  logic [LVL_W-1:0]   fill_level,
  input  logic [ROOT_W-1:0]  fill_root,
  input  logic [CTX_W-1:0]   fill_ctx,
  input  logic [VA_HI_W-1:0] fill_va_hi,
  input  logic [BASE_W-1:0]  fill_base,
  input  logic               inv_valid,
  input  logic [VA_HI_W-1:0] inv_va_hi,
  input  logic               promo_valid,
  input  logic [VA_HI_W-1:0] promo_va_hi,
  input  logic               ctxsw_valid,
  input  logic               ctxsw_keep,
  input  logic [CTX_W-1:0]   ctxsw_ctx
);
  logic [LVLS-1:0]        lvl_hit;
  logic [LVLS*BASE_W-1:0] lvl_base;
  hit_lvl_t               pick_level;
  logic [BASE_W-1:0]      pick_base;

  logic                   flush_all, flush_ctx_en;
  assign flush_all    = ctxsw_valid && !ctxsw_keep;
  assign flush_ctx_en = ctxsw_valid &&  ctxsw_keep;

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    localparam int PW = pfx_width(g);
    logic          fill_en, promo_en;
    logic [PW-1:0] promo_pfx;

    assign fill_en = fill_valid && (fill_level == LVL_W'(g + 1));

    if (g == LVLS - 1) begin : g_leafside
      assign promo_en  = promo_valid;
      assign promo_pfx = promo_va_hi[VA_HI_W-1 -: PW];
    end else begin : g_upper
      assign promo_en  = 1'b0;
      assign promo_pfx = '0;
    end

    pwc_level #(
      .ENTRIES(ENTRIES), .PW(PW), .ROOT_W(ROOT_W), .CTX_W(CTX_W), .BASE_W(BASE_W)
    ) u_arr (
      .clk         (clk),
      .rst_n       (rst_n),
      .lk_root     (lk_root),
      .lk_ctx      (lk_ctx),
      .lk_pfx      (lk_va_hi[VA_HI_W-1 -: PW]),
      .hit         (lvl_hit[g]),
      .hit_base    (lvl_base[g*BASE_W +: BASE_W]),
      .fill_en     (fill_en),
      .fill_root   (fill_root),
      .fill_ctx    (fill_ctx),
      .fill_pfx    (fill_va_hi[VA_HI_W-1 -: PW]),
      .fill_base   (fill_base),
      .kill_a_en   (inv_valid),
      .kill_a_pfx  (inv_va_hi[VA_HI_W-1 -: PW]),
      .kill_b_en   (promo_en),
      .kill_b_pfx  (promo_pfx),
      .flush_all   (flush_all),
      .flush_ctx_en(flush_ctx_en),
      .flush_ctx   (ctxsw_ctx)
    );
  end

  pwc_pick #(.BASE_W(BASE_W)) u_pick (
    .hit      (lvl_hit),
    .base_flat(lvl_base),
    .level    (pick_level),
    .base     (pick_base)
  );

  logic              rsp_valid_d;
  hit_lvl_t          rsp_level_d;
  logic [BASE_W-1:0] rsp_base_d;

  always_comb begin
    rsp_valid_d = lk_valid;
    rsp_level_d = lk_valid ? pick_level : '0;
    rsp_base_d  = lk_valid ? pick_base  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_level <= '0;
      rsp_base  <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_level <= rsp_level_d;
      rsp_base  <= rsp_base_d;
    end
  end
endmodule

// File: rtl/pwc_chk.sv
module pwc_chk #(
  parameter int ROOT_W = 40,
  parameter int CTX_W  = 12,
  parameter int BASE_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ROOT_W-1:0] lk_root,
  input logic [CTX_W-1:0]  lk_ctx,
  input logic [26:0]       lk_va_hi,
  input logic              rsp_valid,
  input logic [1:0]        rsp_level,
  input logic [BASE_W-1:0] rsp_base,
  input logic              fill_valid,
  input logic [1:0]        fill_level,
  input logic [ROOT_W-1:0] fill_root,
  input logic [CTX_W-1:0]  fill_ctx,
  input logic [26:0]       fill_va_hi,
  input logic [BASE_W-1:0] fill_base,
  input logic              inv_valid,
  input logic [26:0]       inv_va_hi,
  input logic              promo_valid,
  input logic              ctxsw_valid,
  input logic              ctxsw_keep
);
  // R1
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_level == 2'd0 && rsp_base == '0));

  // R2 R3
  deep_fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_level == 2'd3 && !inv_valid && !promo_valid && !ctxsw_valid)
    ##1 (lk_valid && lk_va_hi == $past(fill_va_hi) && lk_root == $past(fill_root)
         && lk_ctx == $past(fill_ctx))
    |=> (rsp_level == 2'd3 && rsp_base == $past(fill_base, 2)));

  // R7
  inv_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !fill_valid) ##1 (lk_valid && lk_va_hi == $past(inv_va_hi) && !fill_valid)
    |=> (rsp_level == 2'd0));

  // R8
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctxsw_valid && !ctxsw_keep && !fill_valid) ##1 (lk_valid && !fill_valid)
    |=> (rsp_level == 2'd0));

  // R11
  fill_beats_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_level == 2'd1 && ctxsw_valid && !ctxsw_keep && !inv_valid && !promo_valid)
    ##1 (lk_valid && lk_va_hi[26:18] == $past(fill_va_hi[26:18]) && lk_root == $past(fill_root)
         && lk_ctx == $past(fill_ctx) && !inv_valid && !promo_valid && !ctxsw_valid)
    |=> (rsp_level != 2'd0));
endmodule

bind walk_base_cache pwc_chk #(.ROOT_W(ROOT_W), .CTX_W(CTX_W), .BASE_W(BASE_W)) u_chk (.*);

// File: tb/sim_walk_base_cache.sv
module sim_walk_base_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int RW = 40;
  localparam int CW = 12;
  localparam int BW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          lk_valid = 0;   logic [RW-1:0] lk_root = 0;
  logic [CW-1:0] lk_ctx = 0;     logic [26:0]   lk_va_hi = 0;
  logic          rsp_valid;      logic [1:0]    rsp_level;
  logic [BW-1:0] rsp_base;
  logic          fill_valid = 0; logic [1:0]    fill_level = 0;
  logic [RW-1:0] fill_root = 0;  logic [CW-1:0] fill_ctx = 0;
  logic [26:0]   fill_va_hi = 0; logic [BW-1:0] fill_base = 0;
  logic          inv_valid = 0;  logic [26:0]   inv_va_hi = 0;
  logic          promo_valid = 0; logic [26:0]  promo_va_hi = 0;
  logic          ctxsw_valid = 0; logic ctxsw_keep = 0;
  logic [CW-1:0] ctxsw_ctx = 0;

  walk_base_cache u0 (.*);

  int tests = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference: slots per level with a replacement pointer
  bit          m_v   [3][N];
  logic [RW-1:0] m_root[3][N];
  logic [CW-1:0] m_ctx [3][N];
  logic [26:0] m_pfx [3][N];
  logic [BW-1:0] m_base[3][N];
  int          m_ptr [3];
  bit          e_valid; int e_level; logic [BW-1:0] e_base;

  function automatic logic [26:0] pf(input logic [26:0] va, input int l);
    return va >> (9 * (2 - l));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[l, i]) m_v[l][i] = 0;
      foreach (m_ptr[l]) m_ptr[l] = 0;
      e_valid = 0; e_level = 0; e_base = 0;
    end else begin
      int fl, di;
      e_valid = lk_valid; e_level = 0; e_base = 0;
      if (lk_valid)
        for (int l = 0; l < 3; l++)
          for (int i = 0; i < N; i++)
            if (m_v[l][i] && m_root[l][i] == lk_root && m_ctx[l][i] == lk_ctx &&
                m_pfx[l][i] == pf(lk_va_hi, l)) begin
              e_level = l + 1; e_base = m_base[l][i];
            end
      fl = (fill_valid && fill_level != 0) ? int'(fill_level) - 1 : -1;
      di = -1;
      if (fl >= 0)
        for (int i = 0; i < N; i++)
          if (m_v[fl][i] && m_root[fl][i] == fill_root && m_ctx[fl][i] == fill_ctx &&
              m_pfx[fl][i] == pf(fill_va_hi, fl)) di = i;
      for (int l = 0; l < 3; l++)
        for (int i = 0; i < N; i++) begin
          if (ctxsw_valid && (!ctxsw_keep || m_ctx[l][i] == ctxsw_ctx)) m_v[l][i] = 0;
          if (inv_valid && m_pfx[l][i] == pf(inv_va_hi, l)) m_v[l][i] = 0;
          if (promo_valid && l == 2 && m_pfx[l][i] == promo_va_hi) m_v[l][i] = 0;
        end
      if (fl >= 0) begin
        if (di < 0) begin di = m_ptr[fl]; m_ptr[fl] = (m_ptr[fl] + 1) % N; end
        m_v[fl][di] = 1; m_root[fl][di] = fill_root; m_ctx[fl][di] = fill_ctx;
        m_pfx[fl][di] = pf(fill_va_hi, fl); m_base[fl][di] = fill_base;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      tests++;
      if (rsp_valid !== e_valid || int'(rsp_level) != e_level || rsp_base !== e_base) begin
        fails++;
        $display("FAIL %s model: got v=%0b lvl=%0d base=%h exp v=%0b lvl=%0d base=%h",
                 cur_req, rsp_valid, rsp_level, rsp_base, e_valid, e_level, e_base);
      end
    end
  end

  task automatic chk(input string req, input int lvl, input logic [BW-1:0] base);
    tests++;
    if (rsp_valid !== 1'b1 || int'(rsp_level) != lvl || rsp_base !== base) begin
      fails++;
      $display("FAIL %s: got v=%0b lvl=%0d base=%h exp v=1 lvl=%0d base=%h",
               req, rsp_valid, rsp_level, rsp_base, lvl, base);
    end
  endtask

  task automatic look(input logic [RW-1:0] r, input logic [CW-1:0] c, input logic [26:0] va,
                      input int lvl, input logic [BW-1:0] base, input string req);
    cur_req = req;
    @(negedge clk); lk_valid = 1; lk_root = r; lk_ctx = c; lk_va_hi = va;
    @(negedge clk); lk_valid = 0;
    chk(req, lvl, base);
  endtask

  task automatic fill(input int lv, input logic [RW-1:0] r, input logic [CW-1:0] c,
                      input logic [26:0] va, input logic [BW-1:0] b);
    @(negedge clk); fill_valid = 1; fill_level = 2'(lv); fill_root = r; fill_ctx = c;
    fill_va_hi = va; fill_base = b;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic ctxsw(input bit keep, input logic [CW-1:0] c);
    @(negedge clk); ctxsw_valid = 1; ctxsw_keep = keep; ctxsw_ctx = c;
    @(negedge clk); ctxsw_valid = 0;
  endtask

  localparam logic [RW-1:0] RA = 40'h0_0000_1000;
  localparam logic [26:0] V1  = {9'h011, 9'h022, 9'h033};
  localparam logic [26:0] V1B = {9'h011, 9'h022, 9'h034};
  localparam logic [26:0] V2  = {9'h055, 9'h066, 9'h077};
  localparam logic [26:0] V3  = {9'h0AA, 9'h000, 9'h001};
  localparam logic [26:0] V4  = {9'h0BB, 9'h000, 9'h002};

  function automatic logic [26:0] vr(input int i);
    return {9'(16 + i), 18'h0};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (rsp_valid !== 1'b0 || rsp_level !== 2'd0 || rsp_base !== '0) begin
      fails++;
      $display("FAIL R1 reset: got v=%0b lvl=%0d exp v=0 lvl=0", rsp_valid, rsp_level);
    end
    look(RA, 1, V1, 0, 0, "R1");

    fill(1, RA, 1, V1, 40'hA1);
    look(RA, 1, V1, 1, 40'hA1, "R2");
    look(RA + 1, 1, V1, 0, 0, "R2");
    fill(2, RA, 1, V1, 40'hA2);
    fill(3, RA, 1, V1, 40'hA3);
    look(RA, 1, V1, 3, 40'hA3, "R3");
    look(RA, 1, V1B, 2, 40'hA2, "R3");

    look(RA, 2, V1, 0, 0, "R4");
    fill(1, RA, 2, V1, 40'hC1);
    look(RA, 2, V1, 1, 40'hC1, "R4");
    look(RA, 1, V1, 3, 40'hA3, "R4");

    fill(0, RA, 1, V2, 40'hEE);
    look(RA, 1, V2, 0, 0, "R12");

    cur_req = "R10";
    @(negedge clk); promo_valid = 1; promo_va_hi = V1;
    @(negedge clk); promo_valid = 0;
    look(RA, 1, V1, 2, 40'hA2, "R10");
    look(RA, 2, V1, 1, 40'hC1, "R10");

    fill(1, RA, 1, V2, 40'hD1);
    cur_req = "R7";
    @(negedge clk); inv_valid = 1; inv_va_hi = V1;
    @(negedge clk); inv_valid = 0;
    look(RA, 1, V1, 0, 0, "R7");
    look(RA, 2, V1, 0, 0, "R7");
    look(RA, 1, V2, 1, 40'hD1, "R7");

    fill(1, RA, 2, V2, 40'hE1);
    cur_req = "R9";
    ctxsw(1, 1);
    look(RA, 1, V2, 0, 0, "R9");
    look(RA, 2, V2, 1, 40'hE1, "R9");
    cur_req = "R8";
    ctxsw(0, 0);
    look(RA, 2, V2, 0, 0, "R8");

    // level-1 pointer stands at slot 4 here
    cur_req = "R6";
    for (int i = 0; i < 9; i++) fill(1, RA, 3, vr(i), 40'(256 + i));
    look(RA, 3, vr(0), 0, 0, "R6");
    look(RA, 3, vr(1), 1, 40'd257, "R6");
    look(RA, 3, vr(8), 1, 40'd264, "R6");

    cur_req = "R5";
    fill(1, RA, 3, vr(3), 40'h200);
    fill(1, RA, 3, vr(9), 40'd265);
    look(RA, 3, vr(3), 1, 40'h200, "R5");
    look(RA, 3, vr(2), 1, 40'd258, "R5");
    look(RA, 3, vr(1), 0, 0, "R6");
    look(RA, 3, vr(9), 1, 40'd265, "R5");

    cur_req = "R11";
    @(negedge clk);
    fill_valid = 1; fill_level = 1; fill_root = RA; fill_ctx = 7; fill_va_hi = V3;
    fill_base = 40'hF1; ctxsw_valid = 1; ctxsw_keep = 0;
    @(negedge clk); fill_valid = 0; ctxsw_valid = 0;
    look(RA, 7, V3, 1, 40'hF1, "R11");
    look(RA, 3, vr(2), 0, 0, "R11");

    @(negedge clk);
    lk_valid = 1; lk_root = RA; lk_ctx = 7; lk_va_hi = V4;
    fill_valid = 1; fill_level = 1; fill_root = RA; fill_ctx = 7; fill_va_hi = V4;
    fill_base = 40'hF2;
    @(negedge clk); lk_valid = 0; fill_valid = 0;
    chk("R11", 0, 0);
    look(RA, 7, V4, 1, 40'hF2, "R11");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; tests++;
    $display("FAIL watchdog: got running exp finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule